// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Processor

This block is a compact processor built around one 16-bit accumulator. It keeps its program and data in an internal word-addressed memory. Each instruction runs in two phases of four timing steps each. The phase is held in a fetch/execute flip-flop, and the step is held in a two-bit sequence counter. A run flip-flop gates every register. While the flag is clear the machine is frozen, and the memory can be filled through a preload port. A pulse on `start` lets the processor run until it executes a halt.

The controller is a state machine with nine named states. STOPPED is the state with the run flip-flop clear. FETCH_T0 to FETCH_T3 and EXEC_T0 to EXEC_T3 are the running states.
- START moves STOPPED to FETCH_T0 of the instruction at the current program counter.
- Each step advances to the next step of the same phase.
- FETCH_T3 moves to EXEC_T0. EXEC_T3 moves to FETCH_T0.
- For a halt instruction, HALT moves EXEC_T3 to STOPPED.
- RESET moves any state to STOPPED.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous reset clears the program counter, the accumulator and the extension bit, and leaves the machine stopped (`run_o`=0) in the fetch phase at step 0.
- R2: While stopped, the program counter, accumulator and extension bit hold their values. A preload write (`ld_en`) stores `ld_data` at `ld_addr`. A `start` pulse sets `run_o` on the following edge.
- R3: Every instruction takes exactly 8 cycles. The word format is opcode in bits 15:12 and address in bits 11:0. The first running edge loads the address register from the program counter. The second edge reads the word and increments the program counter.
- R4: Opcode 0 replaces the accumulator with its bitwise AND with the addressed word. The extension bit is unchanged.
- R5: Opcode 1 adds the addressed word to the accumulator. The carry out goes to the extension bit.
- R6: Opcode 2 writes the accumulator to the addressed word.
- R7: Opcode 3 adds one to the addressed word and writes it back. If the result is zero, the program counter skips one extra word.
- R8: Opcode 4 loads the program counter with the address field.
- R9: Opcode 5 writes the return address (the program counter after fetch, zero-extended) to the addressed word. It then continues at that address plus one.
- R10: Opcode 7 clears `run_o` at the end of its execute phase. A later `start` resumes at the following word.
- R11: Opcodes 6 and 8 to 15 change nothing but the program counter advance of fetch.
- R12: `start` and `ld_en` have no effect while `run_o` is 1.
- R13: The memory holds 2^MEM_AW words. Operand addresses select the word given by their low MEM_AW bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Sets the run flip-flop while stopped |
| ld_en | input | 1 | Preload write strobe, honoured while stopped |
| ld_addr | input | MEM_AW | Preload word index |
| ld_data | input | WORD_W | Preload word |
| acc_o | output | WORD_W | Accumulator |
| ext_o | output | 1 | Accumulator extension bit |
| pc_o | output | ADDR_W | Program counter |
| run_o | output | 1 | Run flip-flop |

## Verification
Counted in cycles from the first running edge of an instruction, the program counter advances at edge 2. The accumulator and the extension bit change at edge 6, and so does a branch target. The increment-and-skip advance lands at edge 7, and a halt clears `run_o` at edge 8. A `start` sampled at one edge shows as `run_o` after that edge. The bench model applies each effect at exactly those edges, and it compares all four outputs at every falling edge, half a cycle after the registers settle. Explicit checks at fixed cycle offsets pin the fetch timing and the final results.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_AND = 4'd0;
    localparam logic [OPC_W-1:0] OPC_ADD = 4'd1;
    localparam logic [OPC_W-1:0] OPC_STO = 4'd2;
    localparam logic [OPC_W-1:0] OPC_ISZ = 4'd3;
    localparam logic [OPC_W-1:0] OPC_BUN = 4'd4;
    localparam logic [OPC_W-1:0] OPC_BSB = 4'd5;
    localparam logic [OPC_W-1:0] OPC_HLT = 4'd7;

    // timing step within a phase (sequence counter)
    typedef enum logic [1:0] {
        PH_T0 = 2'd0,
        PH_T1 = 2'd1,
        PH_T2 = 2'd2,
        PH_T3 = 2'd3
    } phase_e;

    // source of a memory write
    typedef enum logic [1:0] {
        WS_ACC = 2'd0,
        WS_PC  = 2'd1,
        WS_MBR = 2'd2
    } wsrc_e;

    typedef struct packed {
        logic  mar_pc;    // address reg <- program counter
        logic  mbr_rd;    // buffer reg <- memory
        logic  pc_inc;    // program counter + 1
        logic  dec;       // address reg <- address field
        logic  acc_and;
        logic  acc_add;
        logic  mbr_inc;
        logic  pc_jmp;    // program counter <- address reg
        logic  pc_jmp1;   // program counter <- address reg + 1
        logic  mem_we;
        wsrc_e wsrc;
    } ctl_t;

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
    parameter int WORD_W = 16,
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              cpu_we,
    input  logic [MEM_AW-1:0] cpu_idx,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic              ld_we,
    input  logic [MEM_AW-1:0] ld_idx,
    input  logic [WORD_W-1:0] ld_wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (cpu_we) begin
            mem_q[cpu_idx] <= cpu_wdata;
        end else if (ld_we) begin
            mem_q[ld_idx] <= ld_wdata;
        end
    end

    assign rdata = mem_q[cpu_idx];

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [OPC_W-1:0] opc_i,
    input  logic             mbr_zero_i,
    output ctl_t             ctl_o,
    output logic             run_o
);
    logic             s_q;   // run flip-flop
    logic             f_q;   // 0 fetch, 1 execute
    phase_e           sc_q;  // sequence counter
    logic [OPC_W-1:0] ir_q;

    // state register process
    always_ff @(posedge clk) begin
        if (rst) begin
            s_q  <= 1'b0;
            f_q  <= 1'b0;
            sc_q <= PH_T0;
            ir_q <= '0;
        end else if (!s_q) begin
            if (start) begin
                s_q <= 1'b1;
            end
        end else begin
            sc_q <= phase_e'(sc_q + 2'd1);
            if (sc_q == PH_T3) begin
                f_q <= ~f_q;
            end
            if (!f_q && sc_q == PH_T2) begin
                ir_q <= opc_i;
            end
            if (f_q && sc_q == PH_T3 && ir_q == OPC_HLT) begin
                s_q <= 1'b0;
            end
        end
    end

    // output process
    always_ff @(posedge clk) begin : p_unused
    end

    always_comb begin
        ctl_o      = '0;
        ctl_o.wsrc = WS_ACC;
        if (s_q) begin
            if (!f_q) begin
                unique case (sc_q)
                    PH_T0: ctl_o.mar_pc = 1'b1;
                    PH_T1: begin
                        ctl_o.mbr_rd = 1'b1;
                        ctl_o.pc_inc = 1'b1;
                    end
                    PH_T2: ctl_o.dec = 1'b1;
                    PH_T3: ;
                endcase
            end else begin
                unique case (sc_q)
                    PH_T0: ctl_o.mbr_rd = 1'b1;
                    PH_T1: begin
                        case (ir_q)
                            OPC_AND: ctl_o.acc_and = 1'b1;
                            OPC_ADD: ctl_o.acc_add = 1'b1;
                            OPC_STO: ctl_o.mem_we  = 1'b1;
                            OPC_ISZ: ctl_o.mbr_inc = 1'b1;
                            OPC_BUN: ctl_o.pc_jmp  = 1'b1;
                            OPC_BSB: begin
                                ctl_o.mem_we  = 1'b1;
                                ctl_o.wsrc    = WS_PC;
                                ctl_o.pc_jmp1 = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                    PH_T2: begin
                        if (ir_q == OPC_ISZ) begin
                            ctl_o.mem_we = 1'b1;
                            ctl_o.wsrc   = WS_MBR;
                            ctl_o.pc_inc = mbr_zero_i;
                        end
                    end
                    PH_T3: ;
                endcase
            end
        end
    end

    assign run_o = s_q;

    // R3: the last fetch step hands over to the first execute step
    a_r3_fetch_to_exec: assert property (@(posedge clk) disable iff (rst)
        (s_q && !f_q && sc_q == PH_T3) |=> (s_q && f_q && sc_q == PH_T0));

    // R10: a halt ends its execute phase in the stopped state
    a_r10_halt_stops: assert property (@(posedge clk) disable iff (rst)
        (s_q && f_q && sc_q == PH_T3 && ir_q == OPC_HLT) |=> (!s_q && !f_q && sc_q == PH_T0));

    // R2: the sequence counter does not move while stopped
    a_r2_seq_frozen: assert property (@(posedge clk) disable iff (rst)
        (!s_q) |=> ($stable(sc_q) && $stable(f_q)));

endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
    import acc_cpu_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 12,
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  ctl_t              ctl_i,
    input  logic [WORD_W-1:0] rdata_i,
    output logic [MEM_AW-1:0] idx_o,
    output logic [WORD_W-1:0] wdata_o,
    output logic [OPC_W-1:0]  opc_o,
    output logic              mbr_zero_o,
    output logic [WORD_W-1:0] acc_o,
    output logic              ext_o,
    output logic [ADDR_W-1:0] pc_o
);
    localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
    localparam logic [WORD_W-1:0] W_ONE = WORD_W'(1);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] mar_q;
    logic [WORD_W-1:0] mbr_q;
    logic [WORD_W-1:0] acc_q;
    logic              e_q;
    logic [WORD_W:0]   sum;

    assign sum = {1'b0, acc_q} + {1'b0, mbr_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            mar_q <= '0;
            mbr_q <= '0;
            acc_q <= '0;
            e_q   <= 1'b0;
        end else begin
            if (ctl_i.mar_pc)  mar_q <= pc_q;
            if (ctl_i.dec)     mar_q <= mbr_q[ADDR_W-1:0];
            if (ctl_i.mbr_rd)  mbr_q <= rdata_i;
            if (ctl_i.mbr_inc) mbr_q <= mbr_q + W_ONE;
            if (ctl_i.pc_inc)  pc_q  <= pc_q + A_ONE;
            if (ctl_i.pc_jmp)  pc_q  <= mar_q;
            if (ctl_i.pc_jmp1) pc_q  <= mar_q + A_ONE;
            if (ctl_i.acc_and) acc_q <= acc_q & mbr_q;
            if (ctl_i.acc_add) {e_q, acc_q} <= sum;
        end
    end

    always_comb begin
        unique case (ctl_i.wsrc)
            WS_PC:   wdata_o = {{(WORD_W-ADDR_W){1'b0}}, pc_q};
            WS_MBR:  wdata_o = mbr_q;
            default: wdata_o = acc_q;
        endcase
    end

    assign idx_o      = mar_q[MEM_AW-1:0];
    assign opc_o      = mbr_q[WORD_W-1 -: OPC_W];
    assign mbr_zero_o = (mbr_q == '0);
    assign acc_o      = acc_q;
    assign ext_o      = e_q;
    assign pc_o       = pc_q;

    // R2: architectural registers frozen while stopped
    a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run_i) |=> ($stable(pc_q) && $stable(acc_q) && $stable(e_q)));

    // R3: the program counter moves only on fetch advance, branch or skip steps
    a_r3_pc_quiet: assert property (@(posedge clk) disable iff (rst)
        (run_i && !ctl_i.pc_inc && !ctl_i.pc_jmp && !ctl_i.pc_jmp1) |=> $stable(pc_q));

    // R4: the extension bit is touched only by an add
    a_r4_ext_only_on_add: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.acc_add) |=> $stable(e_q));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 12,
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ld_en,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    output logic [WORD_W-1:0] acc_o,
    output logic              ext_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic              run_o
);
    ctl_t              ctl;
    logic              run;
    logic [OPC_W-1:0]  opc;
    logic              mbr_zero;
    logic [MEM_AW-1:0] idx;
    logic [WORD_W-1:0] wdata;
    logic [WORD_W-1:0] rdata;
    logic              ld_we;

    assign ld_we = ld_en & ~run;

    acc_cpu_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .opc_i      (opc),
        .mbr_zero_i (mbr_zero),
        .ctl_o      (ctl),
        .run_o      (run)
    );

    acc_cpu_dp #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W),
        .MEM_AW (MEM_AW)
    ) u_dp (
        .clk        (clk),
        .rst        (rst),
        .run_i      (run),
        .ctl_i      (ctl),
        .rdata_i    (rdata),
        .idx_o      (idx),
        .wdata_o    (wdata),
        .opc_o      (opc),
        .mbr_zero_o (mbr_zero),
        .acc_o      (acc_o),
        .ext_o      (ext_o),
        .pc_o       (pc_o)
    );

    acc_cpu_mem #(
        .WORD_W (WORD_W),
        .MEM_AW (MEM_AW)
    ) u_mem (
        .clk       (clk),
        .cpu_we    (ctl.mem_we),
        .cpu_idx   (idx),
        .cpu_wdata (wdata),
        .ld_we     (ld_we),
        .ld_idx    (ld_addr),
        .ld_wdata  (ld_data),
        .rdata     (rdata)
    );

    assign run_o = run;

    // R12: no processor write and preload write can coincide
    a_r12_single_writer: assert property (@(posedge clk) disable iff (rst)
        !(ctl.mem_we && ld_we));

endmodule

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [15:0] acc_o;
    logic        ext_o;
    logic [11:0] pc_o;
    logic        run_o;

    always #5 clk = ~clk;

    acc_cpu dut (
        .clk(clk), .rst(rst), .start(start), .ld_en(ld_en),
        .ld_addr(ld_addr), .ld_data(ld_data),
        .acc_o(acc_o), .ext_o(ext_o), .pc_o(pc_o), .run_o(run_o)
    );

    int vectors = 0;
    int errors  = 0;
    bit cmp_en  = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference: instruction effects placed at their cycle offsets
    logic [15:0] m [256];
    logic [15:0] macc;
    logic        me;
    logic [11:0] mpc;
    bit          ms;
    int          mk;
    logic [15:0] minst;

    always @(posedge clk) begin
        if (rst) begin
            macc = 0; me = 0; mpc = 0; ms = 0; mk = 0;
        end else if (!ms) begin
            if (ld_en) m[ld_addr] = ld_data;
            if (start) ms = 1;
        end else begin
            int idx;
            idx = int'(minst[11:0]) % 256;
            if (mk == 1) begin
                minst = m[mpc % 256];
                mpc   = mpc + 1;
            end
            if (mk == 5) begin
                idx = int'(minst[11:0]) % 256;
                case (minst[15:12])
                    4'd0: macc = macc & m[idx];
                    4'd1: {me, macc} = {1'b0, macc} + {1'b0, m[idx]};
                    4'd2: m[idx] = macc;
                    4'd3: m[idx] = m[idx] + 16'd1;
                    4'd4: mpc = minst[11:0];
                    4'd5: begin m[idx] = {4'd0, mpc}; mpc = minst[11:0] + 12'd1; end
                    default: ;
                endcase
            end
            if (mk == 6 && minst[15:12] == 4'd3 && m[idx] == 16'd0) mpc = mpc + 1;
            if (mk == 7 && minst[15:12] == 4'd7) ms = 0;
            mk = (mk + 1) % 8;
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            check("R5 accumulator vs model", {16'd0, acc_o}, {16'd0, macc});
            check("R5 extension vs model", {31'd0, ext_o}, {31'd0, me});
            check("R3 program counter vs model", {20'd0, pc_o}, {20'd0, mpc});
            check("R10 run flag vs model", {31'd0, run_o}, {31'd0, ms});
        end
    end

    task automatic put(input int a, input logic [15:0] d);
        ld_en = 1'b1; ld_addr = a[7:0]; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_stop();
        int n;
        n = 0;
        while (run_o && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (run_o) check("watchdog: run did not end", 32'd1, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp_en = 1'b1;
        // R1: reset state
        check("R1 pc after reset", {20'd0, pc_o}, 32'd0);
        check("R1 acc after reset", {16'd0, acc_o}, 32'd0);
        check("R1 run after reset", {31'd0, run_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < 256; i++) put(i, 16'h0000);
        put(0, 16'h1014);   // ADD 20
        put(1, 16'h0015);   // AND 21
        put(2, 16'h1016);   // ADD 22 -> carry
        put(3, 16'h2017);   // STO 23
        put(4, 16'h3018);   // ISZ 24 -> skips
        put(5, 16'h1016);   // must be skipped
        put(6, 16'h3019);   // ISZ 25 -> no skip
        put(7, 16'h501E);   // BSB 30
        put(8, 16'h7000);   // HLT
        put(9, 16'h6000);   // undefined opcode
        put(10, 16'h001A);  // AND 26
        put(11, 16'h7000);
        put(12, 16'h1114);  // ADD 0x114 aliases word 20
        put(13, 16'h7000);
        put(14, 16'h400E);  // BUN 14, endless
        put(20, 16'h0005);
        put(21, 16'h0007);
        put(22, 16'hFFFF);
        put(24, 16'hFFFF);
        put(25, 16'h0003);
        put(31, 16'h1017);  // ADD 23
        put(32, 16'h1019);  // ADD 25
        put(33, 16'h1018);  // ADD 24
        put(34, 16'h101E);  // ADD 30
        put(35, 16'h4008);  // BUN 8
        // R2: preload while stopped leaves registers alone
        check("R2 pc held while stopped", {20'd0, pc_o}, 32'd0);
        check("R2 run still clear", {31'd0, run_o}, 32'd0);

        pulse_start();
        check("R2 run set after start", {31'd0, run_o}, 32'd1);
        @(negedge clk);
        check("R3 pc before fetch advance", {20'd0, pc_o}, 32'd0);
        @(negedge clk);
        check("R3 pc after second running edge", {20'd0, pc_o}, 32'd1);
        // R12: these must be ignored while running
        start = 1'b1; ld_en = 1'b1; ld_addr = 8'd26; ld_data = 16'hFFFF;
        @(negedge clk);
        start = 1'b0; ld_en = 1'b0;
        wait_stop();
        check("R6 R7 R9 final accumulator", {16'd0, acc_o}, 32'd20);
        check("R8 BUN then halt leaves pc", {20'd0, pc_o}, 32'd9);
        check("R5 carry cleared by later add", {31'd0, ext_o}, 32'd0);
        check("R10 halted", {31'd0, run_o}, 32'd0);

        pulse_start();
        wait_stop();
        check("R11 undefined opcode passes", {20'd0, pc_o}, 32'd12);
        check("R12 preload during run ignored", {16'd0, acc_o}, 32'd0);
        check("R4 AND keeps extension", {31'd0, ext_o}, 32'd0);

        pulse_start();
        wait_stop();
        check("R13 aliased operand", {16'd0, acc_o}, 32'd5);

        pulse_start();
        repeat (20) @(negedge clk);
        check("R10 loop still running", {31'd0, run_o}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset mid-run pc", {20'd0, pc_o}, 32'd0);
        check("R1 reset mid-run acc", {16'd0, acc_o}, 32'd0);
        check("R1 reset mid-run run", {31'd0, run_o}, 32'd0);
        repeat (10) @(negedge clk);
        check("R2 frozen after reset", {20'd0, pc_o}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        vectors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule